// File: doc/BRIEF.md
# Memory-mapped SPI flash read engine

This block serves word reads from a memory window by running a complete read sequence on an external serial flash. Each chip select has its own setup word, which gives the read opcode, how many address bytes follow it, how many dummy bytes come next, and how many data lanes carry the reply. A read request names a chip select and a byte offset inside the window. The engine selects that device, shifts out the opcode and the address on a single lane, idles through the dummy bytes with every data line released, and then gathers 32 data bits on one, two or four lanes. It hands the word back and releases the chip select.

A single ownership bit decides who drives the serial pins. When it is set, this engine drives the pins. When it is clear, the pins follow a separate command-mode port, and reads through the window are answered at once with an error flag. A read whose four bytes would not all fit inside the window is also answered with the error flag, and the engine starts no serial traffic for it. The requester holds its request until the one-cycle response strobe, so a read simply stalls for as long as the flash sequence takes.

Top module: `spi_mmap_reader`

## Requirements
- R1: The setup word for a chip select is written at configuration index k (k = 0 .. NUM_CS-1). Its bits 7:0 hold the opcode. The opcode is shifted out first, MSB first, on IO0, and during opcode and address bits only IO0 is driven (output enables = 4'b0001).
- R2: Setup bits 9:8 hold the address byte count minus one (1 to 4 bytes). The engine sends that many low-order bytes of the byte offset, MSB first, on IO0, straight after the opcode.
- R3: Setup bits 11:10 hold the dummy byte count (0 to 3). Each dummy byte lasts 8 SCLK periods with all four output enables low, and output enables stay low through the data phase.
- R4: Setup bits 13:12 select the lane mode. Value 0 is single lane (data on IO1), 1 is dual lane (IO1:IO0, IO1 the higher bit), 3 is quad lane (IO3:IO0, IO3 the highest bit), and the unused value 2 behaves as single lane. Data is assembled MSB first, so the byte at the offset ends up in bits 31:24 of the returned word.
- R5: During a read, exactly the chip select line of the requested device is low, and no other line is low. All chip selects are high again by the time the response is signalled.
- R6: Bit 0 written at configuration index NUM_CS is the ownership bit. When it is 1, the engine drives the pins and the command-port pin inputs have no effect. When it is 0, the SCLK, chip select, IO output and IO enable pins equal the command-port inputs, and window reads return with rd_err = 1 without asserting any chip select.
- R7: A read whose offset plus 4 exceeds WIN_BYTES returns rd_err = 1 and starts no serial traffic.
- R8: rd_ready is a single-cycle strobe per accepted request, carrying rd_rdata and rd_err. The request must be held until the strobe.
- R9: After reset the ownership bit is 0, rd_ready is low, and the pins follow the command port.
- R10: SCLK idles low and runs at half the clock rate. A read keeps its chip select low for exactly 2 × (8 + 8·address bytes + 8·dummy bytes + 32/lanes) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Index 0..NUM_CS-1 selects a setup word, NUM_CS selects the ownership bit |
| cfg_wdata | input | 14 | Configuration write data |
| rd_valid | input | 1 | Read request, held until rd_ready |
| rd_cs | input | CS_W | Chip select index of the read |
| rd_addr | input | 32 | Byte offset inside the window |
| rd_ready | output | 1 | One-cycle response strobe |
| rd_rdata | output | 32 | Read word |
| rd_err | output | 1 | Read rejected (window or ownership) |
| cp_sclk | input | 1 | Command-port SCLK |
| cp_cs_n | input | NUM_CS | Command-port chip selects |
| cp_io_out | input | 4 | Command-port IO output values |
| cp_io_oe | input | 4 | Command-port IO output enables |
| spi_sclk | output | 1 | Serial clock pin |
| spi_cs_n | output | NUM_CS | Chip select pins, active low |
| spi_io_out | output | 4 | IO output values |
| spi_io_oe | output | 4 | IO output enables |
| spi_io_in | input | 4 | IO input values |

## Verification
The assertions assume that no configuration write happens while a read sequence is running, and that rd_valid with its chip select and offset stays steady until the response strobe. The bench writes setup words and the ownership bit only between reads, and its driver task holds the request until it sees rd_ready. A behavioural flash in the bench decodes each sequence with its own copy of the setup words. Lane modes, address widths, dummy counts and the window edge are all covered across the four chip selects.

// File: rtl/spi_mmap_pkg.sv
package spi_mmap_pkg;

    localparam int SETUP_W = 14;
    localparam int WORD_W  = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DUMMY,
        ST_DATA,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        LANE_X1   = 2'd0,
        LANE_X2   = 2'd1,
        LANE_RSVD = 2'd2,
        LANE_X4   = 2'd3
    } lane_mode_e;

    // packed MSB first: mode 13:12, dummy 11:10, addr bytes-1 9:8, opcode 7:0
    typedef struct packed {
        lane_mode_e mode;
        logic [1:0] dummy_bytes;
        logic [1:0] addr_bytes_m1;
        logic [7:0] opcode;
    } setup_t;

    function automatic logic [5:0] data_sclks(input lane_mode_e m);
        case (m)
            LANE_X2: data_sclks = 6'd16;
            LANE_X4: data_sclks = 6'd8;
            default: data_sclks = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/spi_mmap_cfg.sv
module spi_mmap_cfg
    import spi_mmap_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CFG_AW = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [SETUP_W-1:0] cfg_wdata,
    output setup_t             setup_arr [NUM_CS],
    output logic               mm_en
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_setup
        always_ff @(posedge clk) begin
            if (rst) begin
                setup_arr[g] <= '0;
            end else if (cfg_wr && cfg_addr == CFG_AW'(g)) begin
                setup_arr[g] <= setup_t'(cfg_wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mm_en <= 1'b0;
        end else if (cfg_wr && cfg_addr == CFG_AW'(NUM_CS)) begin
            mm_en <= cfg_wdata[0];
        end
    end

endmodule

// File: rtl/spi_mmap_seq.sv
module spi_mmap_seq
    import spi_mmap_pkg::*;
#(
    parameter int          NUM_CS    = 4,
    parameter int          CS_W      = 2,
    parameter logic [32:0] WIN_BYTES = 33'h1_0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mm_en,
    input  setup_t            setup_arr [NUM_CS],
    input  logic              rd_valid,
    input  logic [CS_W-1:0]   rd_cs,
    input  logic [31:0]       rd_addr,
    output logic              rd_ready,
    output logic [31:0]       rd_rdata,
    output logic              rd_err,
    output logic              busy,
    output logic              eng_sclk,
    output logic [NUM_CS-1:0] eng_cs_n,
    output logic [3:0]        eng_io_out,
    output logic [3:0]        eng_io_oe,
    input  logic [3:0]        eng_io_in
);

    localparam bit CS_FULL = (1 << CS_W) == NUM_CS;

    seq_state_e        state;
    logic              half;
    logic [5:0]        cnt;
    logic [39:0]       sh_out;
    logic [31:0]       sh_in;
    logic [31:0]       in_next;
    setup_t            cfg_q;
    setup_t            sel;
    logic [CS_W-1:0]   cs_q;
    logic              win_ok;
    logic              cs_ok;
    logic              active;
    logic [4:0]        sh_amt;

    always_comb begin
        sel    = setup_arr[rd_cs];
        win_ok = ({1'b0, rd_addr} + 33'd4) <= WIN_BYTES;
        cs_ok  = CS_FULL ? 1'b1 : ({1'b0, rd_cs} < (CS_W+1)'(NUM_CS));
        sh_amt = {2'd3 - sel.addr_bytes_m1, 3'b000};
        active = (state == ST_CMD) || (state == ST_DUMMY) || (state == ST_DATA);
        case (cfg_q.mode)
            LANE_X2: in_next = {sh_in[29:0], eng_io_in[1:0]};
            LANE_X4: in_next = {sh_in[27:0], eng_io_in[3:0]};
            default: in_next = {sh_in[30:0], eng_io_in[1]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            half     <= 1'b0;
            cnt      <= '0;
            sh_out   <= '0;
            sh_in    <= '0;
            cfg_q    <= '0;
            cs_q     <= '0;
            rd_rdata <= '0;
            rd_err   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rd_valid) begin
                        if (mm_en && win_ok && cs_ok) begin
                            cfg_q  <= sel;
                            cs_q   <= rd_cs;
                            sh_out <= {sel.opcode, rd_addr << sh_amt};
                            cnt    <= 6'd16 + {1'b0, sel.addr_bytes_m1, 3'b000};
                            half   <= 1'b0;
                            state  <= ST_CMD;
                        end else begin
                            rd_err   <= 1'b1;
                            rd_rdata <= '0;
                            state    <= ST_DONE;
                        end
                    end
                end
                ST_CMD, ST_DUMMY, ST_DATA: begin
                    half <= !half;
                    if (half) begin
                        if (state == ST_CMD)  sh_out <= {sh_out[38:0], 1'b0};
                        if (state == ST_DATA) sh_in  <= in_next;
                        cnt <= cnt - 6'd1;
                        if (cnt == 6'd1) begin
                            if (state == ST_CMD) begin
                                if (cfg_q.dummy_bytes != 2'd0) begin
                                    state <= ST_DUMMY;
                                    cnt   <= {1'b0, cfg_q.dummy_bytes, 3'b000};
                                end else begin
                                    state <= ST_DATA;
                                    cnt   <= data_sclks(cfg_q.mode);
                                end
                            end else if (state == ST_DUMMY) begin
                                state <= ST_DATA;
                                cnt   <= data_sclks(cfg_q.mode);
                            end else begin
                                state    <= ST_DONE;
                                rd_rdata <= in_next;
                                rd_err   <= 1'b0;
                            end
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_ready   = (state == ST_DONE);
    assign busy       = (state != ST_IDLE);
    assign eng_sclk   = active && half;
    assign eng_io_out = {3'b000, (state == ST_CMD) && sh_out[39]};
    assign eng_io_oe  = {3'b000, (state == ST_CMD)};

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign eng_cs_n[g] = !(active && cs_q == CS_W'(g));
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~eng_cs_n)); // R5

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_ready |=> !rd_ready); // R8

    AST_WINDOW_REJECT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && rd_valid && !win_ok) |=> (rd_ready && rd_err)); // R7

endmodule

// File: rtl/spi_mmap_pinmux.sv
module spi_mmap_pinmux #(
    parameter int NUM_CS = 4
) (
    input  logic              mm_en,
    input  logic              eng_sclk,
    input  logic [NUM_CS-1:0] eng_cs_n,
    input  logic [3:0]        eng_io_out,
    input  logic [3:0]        eng_io_oe,
    input  logic              cp_sclk,
    input  logic [NUM_CS-1:0] cp_cs_n,
    input  logic [3:0]        cp_io_out,
    input  logic [3:0]        cp_io_oe,
    output logic              spi_sclk,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic [3:0]        spi_io_out,
    output logic [3:0]        spi_io_oe
);

    always_comb begin
        if (mm_en) begin
            spi_sclk   = eng_sclk;
            spi_cs_n   = eng_cs_n;
            spi_io_out = eng_io_out;
            spi_io_oe  = eng_io_oe;
        end else begin
            spi_sclk   = cp_sclk;
            spi_cs_n   = cp_cs_n;
            spi_io_out = cp_io_out;
            spi_io_oe  = cp_io_oe;
        end
    end

endmodule

// File: rtl/spi_mmap_reader.sv
module spi_mmap_reader
    import spi_mmap_pkg::*;
#(
    parameter int          NUM_CS    = 4,
    parameter logic [32:0] WIN_BYTES = 33'h1_0000_0000,
    localparam int         CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int         CFG_AW    = $clog2(NUM_CS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [SETUP_W-1:0] cfg_wdata,
    input  logic               rd_valid,
    input  logic [CS_W-1:0]    rd_cs,
    input  logic [31:0]        rd_addr,
    output logic               rd_ready,
    output logic [31:0]        rd_rdata,
    output logic               rd_err,
    input  logic               cp_sclk,
    input  logic [NUM_CS-1:0]  cp_cs_n,
    input  logic [3:0]         cp_io_out,
    input  logic [3:0]         cp_io_oe,
    output logic               spi_sclk,
    output logic [NUM_CS-1:0]  spi_cs_n,
    output logic [3:0]         spi_io_out,
    output logic [3:0]         spi_io_oe,
    input  logic [3:0]         spi_io_in
);

    setup_t            setup_arr [NUM_CS];
    logic              mm_en;
    logic              busy;
    logic              eng_sclk;
    logic [NUM_CS-1:0] eng_cs_n;
    logic [3:0]        eng_io_out;
    logic [3:0]        eng_io_oe;

    spi_mmap_cfg #(
        .NUM_CS (NUM_CS),
        .CFG_AW (CFG_AW)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .setup_arr (setup_arr),
        .mm_en     (mm_en)
    );

    spi_mmap_seq #(
        .NUM_CS    (NUM_CS),
        .CS_W      (CS_W),
        .WIN_BYTES (WIN_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mm_en      (mm_en),
        .setup_arr  (setup_arr),
        .rd_valid   (rd_valid),
        .rd_cs      (rd_cs),
        .rd_addr    (rd_addr),
        .rd_ready   (rd_ready),
        .rd_rdata   (rd_rdata),
        .rd_err     (rd_err),
        .busy       (busy),
        .eng_sclk   (eng_sclk),
        .eng_cs_n   (eng_cs_n),
        .eng_io_out (eng_io_out),
        .eng_io_oe  (eng_io_oe),
        .eng_io_in  (spi_io_in)
    );

    spi_mmap_pinmux #(
        .NUM_CS (NUM_CS)
    ) u_pinmux (
        .mm_en      (mm_en),
        .eng_sclk   (eng_sclk),
        .eng_cs_n   (eng_cs_n),
        .eng_io_out (eng_io_out),
        .eng_io_oe  (eng_io_oe),
        .cp_sclk    (cp_sclk),
        .cp_cs_n    (cp_cs_n),
        .cp_io_out  (cp_io_out),
        .cp_io_oe   (cp_io_oe),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_io_out (spi_io_out),
        .spi_io_oe  (spi_io_oe)
    );

    AST_SCLK_HAS_CS: assert property (@(posedge clk) disable iff (rst)
        (mm_en && spi_sclk) |-> !(&spi_cs_n)); // R10

    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cfg_wr); // R6

endmodule

// File: tb/spi_mmap_reader_tb.sv
`timescale 1ns/1ps
module spi_mmap_reader_tb;

    localparam int          NCS = 4;
    localparam logic [32:0] WIN = 33'h0200_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [2:0]  cfg_addr;
    logic [13:0] cfg_wdata;
    logic        rd_valid;
    logic [1:0]  rd_cs;
    logic [31:0] rd_addr;
    logic        rd_ready;
    logic [31:0] rd_rdata;
    logic        rd_err;
    logic        cp_sclk;
    logic [3:0]  cp_cs_n;
    logic [3:0]  cp_io_out;
    logic [3:0]  cp_io_oe;
    logic        spi_sclk;
    logic [3:0]  spi_cs_n;
    logic [3:0]  spi_io_out;
    logic [3:0]  spi_io_oe;
    logic [3:0]  f_io;

    always #2.5 clk = ~clk;

    spi_mmap_reader #(.NUM_CS(NCS), .WIN_BYTES(WIN)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_valid(rd_valid), .rd_cs(rd_cs), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_rdata(rd_rdata), .rd_err(rd_err),
        .cp_sclk(cp_sclk), .cp_cs_n(cp_cs_n), .cp_io_out(cp_io_out), .cp_io_oe(cp_io_oe),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out),
        .spi_io_oe(spi_io_oe), .spi_io_in(f_io)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // bench copy of the configuration it has written
    logic [13:0] shadow [NCS];
    bit          sw_on;

    function automatic int lanes_of(input logic [1:0] m);
        if (m == 2'd1) return 2;
        if (m == 2'd3) return 4;
        return 1;
    endfunction

    function automatic logic [7:0] flash_byte(input logic [31:0] a, input int cs);
        logic [7:0] v;
        v = 8'(a[7:0] * 8'd3) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
        return v ^ 8'(cs * 17);
    endfunction

    function automatic logic [31:0] addr_mask(input int nb);
        if (nb == 4) return 32'hFFFF_FFFF;
        return (32'd1 << (8 * nb)) - 32'd1;
    endfunction

    function automatic logic [31:0] flash_word(input logic [31:0] a, input int nb, input int cs);
        logic [31:0] w;
        for (int i = 0; i < 4; i++)
            w[31 - 8*i -: 8] = flash_byte((a + 32'(i)) & addr_mask(nb), cs);
        return w;
    endfunction

    function automatic logic [13:0] mk_setup(input int mode, input int db, input int nb, input logic [7:0] op);
        return {2'(mode), 2'(db), 2'(nb - 1), op};
    endfunction

    // ---------------- behavioural flash ----------------
    logic        cs_act;
    assign cs_act = ~&spi_cs_n;
    int          pc, cyc, f_cs, oe_bad, multi;
    logic [7:0]  f_op;
    logic [31:0] f_addr;
    bit          seen;

    initial begin
        f_io = 4'h0; pc = 0; cyc = 0; f_cs = 0; oe_bad = 0; multi = 0;
        f_op = 8'h0; f_addr = 32'h0; seen = 0;
    end

    always @(posedge cs_act) begin
        pc = 0; cyc = 0; f_op = 8'h0; f_addr = 32'h0; oe_bad = 0; seen = 1; f_io = 4'h0;
        f_cs = 0;
        for (int i = NCS - 1; i >= 0; i--) if (!spi_cs_n[i]) f_cs = i;
        if ($countones(~spi_cs_n) != 1) multi++;
    end

    always @(negedge clk) if (cs_act) cyc++;

    always @(posedge spi_sclk) begin
        if (cs_act) begin
            int nb;
            nb = int'(shadow[f_cs][9:8]) + 1;
            if (pc < 8) begin
                f_op = {f_op[6:0], spi_io_out[0]};
                if (spi_io_oe != 4'b0001) oe_bad++;
            end else if (pc < 8 + 8*nb) begin
                f_addr = {f_addr[30:0], spi_io_out[0]};
                if (spi_io_oe != 4'b0001) oe_bad++;
            end else begin
                if (spi_io_oe != 4'b0000) oe_bad++;
            end
            pc++;
        end
    end

    always @(negedge spi_sclk) begin
        if (cs_act) begin
            int nb, db, hdr, l, k, top;
            logic [31:0] w;
            nb  = int'(shadow[f_cs][9:8]) + 1;
            db  = int'(shadow[f_cs][11:10]);
            hdr = 8 + 8*nb + 8*db;
            l   = lanes_of(shadow[f_cs][13:12]);
            if (pc >= hdr) begin
                k   = pc - hdr;
                top = 31 - k*l;
                w   = flash_word(f_addr, nb, f_cs);
                f_io = 4'h0;
                if (top >= 0) begin
                    if (l == 1) f_io[1] = w[top];
                    else for (int j = 0; j < l; j++) f_io[l-1-j] = w[top-j];
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [31:0] data;
        bit          err;
        logic [7:0]  op;
        logic [31:0] addr;
        int          cs;
        int          pcs;
    } exp_t;

    exp_t exp_q[$];

    task automatic cfg_write(input int idx, input logic [13:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (idx < NCS) shadow[idx] = d;
        else sw_on = d[0];
    endtask

    task automatic do_read(input int cs, input logic [31:0] off);
        exp_t e;
        int   nb, db, l, t;
        nb = int'(shadow[cs][9:8]) + 1;
        db = int'(shadow[cs][11:10]);
        l  = lanes_of(shadow[cs][13:12]);
        e.err  = !sw_on || (({1'b0, off} + 33'd4) > WIN);
        e.addr = off & addr_mask(nb);
        e.data = e.err ? 32'h0 : flash_word(e.addr, nb, cs);
        e.op   = shadow[cs][7:0];
        e.cs   = cs;
        e.pcs  = 8 + 8*nb + 8*db + 32 / l;
        exp_q.push_back(e);
        seen = 0;
        @(negedge clk);
        rd_valid = 1'b1; rd_cs = 2'(cs); rd_addr = off;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!rd_ready && t < 2000);
        rd_valid = 1'b0;
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && rd_ready) begin
            if (exp_q.size() == 0) begin
                chk_eq("R8 response without request", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk_eq("R7 error flag", 32'(rd_err), 32'(e.err));
                if (e.err) begin
                    chk_eq("R6/R7 no chip select on rejected read", 32'(seen), 32'd0);
                end else begin
                    chk_eq("R4 read word", rd_rdata, e.data);
                    chk_eq("R1 opcode on IO0", 32'(f_op), 32'(e.op));
                    chk_eq("R2 address bytes", f_addr, e.addr);
                    chk_eq("R5 selected chip", 32'(f_cs), 32'(e.cs));
                    chk_eq("R3 SCLK count incl dummy", 32'(pc), 32'(e.pcs));
                    chk_eq("R3 output enables per phase", 32'(oe_bad), 32'd0);
                    chk_eq("R10 chip select active cycles", 32'(cyc), 32'(2 * e.pcs));
                    chk_eq("R5 single chip select", 32'(multi), 32'd0);
                    chk_eq("R5 chip selects released", 32'(spi_cs_n), 32'hF);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        rd_valid = 1'b0; rd_cs = '0; rd_addr = '0;
        cp_sclk = 1'b0; cp_cs_n = 4'hF; cp_io_out = 4'h0; cp_io_oe = 4'h0;
        sw_on = 1'b0;
        for (int i = 0; i < NCS; i++) shadow[i] = 14'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        chk_eq("R9 rd_ready after reset", 32'(rd_ready), 32'd0);
        chk_eq("R9 cs_n follows command port", 32'(spi_cs_n), 32'hF);
        chk_eq("R9 sclk low", 32'(spi_sclk), 32'd0);
        chk_eq("R9 io_oe low", 32'(spi_io_oe), 32'd0);

        // R6 pass-through while ownership bit is 0
        cp_sclk = 1'b1; cp_cs_n = 4'b1101; cp_io_out = 4'b0110; cp_io_oe = 4'b1010;
        #1;
        chk_eq("R6 sclk pass-through", 32'(spi_sclk), 32'd1);
        chk_eq("R6 cs_n pass-through", 32'(spi_cs_n), 32'hD);
        chk_eq("R6 io_out pass-through", 32'(spi_io_out), 32'h6);
        chk_eq("R6 io_oe pass-through", 32'(spi_io_oe), 32'hA);
        cp_sclk = 1'b0; cp_cs_n = 4'hF; cp_io_out = 4'h0; cp_io_oe = 4'h0;

        cfg_write(0, mk_setup(0, 0, 3, 8'h03));
        do_read(0, 32'h0000_1234);                 // R6 rejected: engine not owner

        cfg_write(NCS, 14'h1);
        cp_sclk = 1'b1; cp_cs_n = 4'h0; cp_io_oe = 4'hF; cp_io_out = 4'hF;
        @(negedge clk);
        chk_eq("R6 command sclk ignored", 32'(spi_sclk), 32'd0);
        chk_eq("R6 command cs_n ignored", 32'(spi_cs_n), 32'hF);
        chk_eq("R6 command io_oe ignored", 32'(spi_io_oe), 32'd0);
        cp_sclk = 1'b0; cp_cs_n = 4'hF; cp_io_oe = 4'h0; cp_io_out = 4'h0;
        @(negedge clk);

        // lane modes, address widths, dummy counts (R1-related checks per response)
        cfg_write(1, mk_setup(1, 1, 3, 8'h3B));
        cfg_write(2, mk_setup(3, 2, 4, 8'h6C));
        cfg_write(3, mk_setup(0, 3, 4, 8'h0B));
        do_read(0, 32'h0001_2344);
        do_read(1, 32'h00AB_CDE0);
        do_read(2, 32'h01AB_CDEF);
        do_read(3, 32'h0100_0001);
        do_read(2, 32'h0000_0000);

        // back-to-back on different devices
        do_read(1, 32'h0155_AA55);
        do_read(0, 32'h01FF_00FF);

        // reserved lane code behaves as single lane (R4), two address bytes
        cfg_write(3, mk_setup(2, 0, 2, 8'hA5));
        do_read(3, 32'h0000_BEEF);
        cfg_write(0, mk_setup(3, 3, 1, 8'hE7));
        do_read(0, 32'h0000_0042);

        // window edge (R7)
        do_read(2, 32'h01FF_FFFC);
        do_read(2, 32'h01FF_FFFD);
        do_read(1, 32'hFFFF_FFFE);

        // ownership returned to command port (R6)
        cfg_write(NCS, 14'h0);
        do_read(1, 32'h0000_0100);
        cfg_write(NCS, 14'h1);
        do_read(1, 32'h0000_0100);

        repeat (4) @(negedge clk);
        chk_eq("R8 every request answered", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule